// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags and Line Status

This block sits between a UART's receive deserializer and its host register port. The deserializer delivers each character as a push strobe carrying a data byte and three error flags: break, framing and parity. Each character is stored in a first-in first-out queue together with its own flags. The host reads the receive holding value, which pops the queue. The host also reads an 8-bit line status word.

The status word shows the flags of the character that will be read next, not those of the newest arrival. It also has a summary bit that stays set while any errored character is still queued, which it derives from a running count of tagged entries. A sticky overrun bit records characters lost to a full queue. The block also takes the transmit holding FIFO level and the transmit shift register's busy state, and turns them into the two transmit-empty bits.

Top module: `uart_rx_status`

## Requirements
- R1: The queue holds DEPTH characters (64 by default) in arrival order. `rhr_data` shows the oldest stored byte, and a `rd_rhr` strobe removes it on the clock edge. Status bit 0 is 1 exactly when at least one character is stored.
- R2: Status bits 4, 3 and 2 give the break, framing and parity flags of the oldest stored character. The flags of later arrivals do not appear there.
- R3: A character pushed with the break flag is stored as byte 0x00, whatever `push_data` carries.
- R4: Status bit 7 is 1 while any stored character has at least one flag set. It goes to 0 in the cycle after the last such character is read out. A push and a pop in the same cycle keep it correct.
- R5: With the queue empty, status bits 4..2 read 0. A `rd_rhr` on an empty queue changes no state, and `rhr_data` keeps showing the last byte read out (0 after reset).
- R6: A push to a full queue without a pop in the same cycle is discarded and stored data stays intact. Status bit 1 (overrun) then reads 1 from the next cycle. A push to a full queue together with a pop is accepted.
- R7: A `rd_lsr` strobe clears the overrun bit for the next cycle, unless a new overrun happens in that same cycle.
- R8: Status bit 5 is 1 when `tx_level` is 0. Status bit 6 is 1 when `tx_level` is 0 and `tx_shift_busy` is 0.
- R9: A synchronous `rst` takes priority over all strobes. It empties the queue and clears the error count, the overrun bit and the last-read byte. With the transmit side idle, the status word then reads 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Deserializer delivers a character |
| push_data | input | 8 | Received byte |
| push_brk | input | 1 | Break flag of the pushed character |
| push_fe | input | 1 | Framing error flag of the pushed character |
| push_pe | input | 1 | Parity error flag of the pushed character |
| rd_rhr | input | 1 | Host reads the receive holding value (pops) |
| rd_lsr | input | 1 | Host reads the line status word |
| tx_level | input | TXW | Characters held in the transmit FIFO |
| tx_shift_busy | input | 1 | Transmit shift register is sending |
| rhr_data | output | 8 | Receive holding value |
| lsr | output | 8 | Line status word |

## Verification
The bench builds the block with DEPTH 8 and TXW 4. The full queue, overrun with and without a simultaneous pop, and pointer wrap-around therefore come up many times in a few thousand random cycles. A small queue also makes it likely that the only errored entry is popped while a clean one is pushed, and the reverse. These are the cases that test the error counter's same-cycle update. The reference model recomputes the summary bit by scanning its queue, so it shares no counter with the design.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DEPTH = 64,
  parameter int TXW   = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [7:0]     push_data,
  input  logic           push_brk,
  input  logic           push_fe,
  input  logic           push_pe,
  input  logic           rd_rhr,
  input  logic           rd_lsr,
  input  logic [TXW-1:0] tx_level,
  input  logic           tx_shift_busy,
  output logic [7:0]     rhr_data,
  output logic [7:0]     lsr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, err_cnt;
  logic          ovr_q;
  logic [7:0]    last_q;

  wire        empty    = (count == '0);
  wire        full     = (count == CW'(DEPTH));
  wire        pop_ok   = rd_rhr & ~empty;
  wire        push_ok  = push & (~full | pop_ok);
  wire        ovf      = push & ~push_ok;
  wire [10:0] head     = mem[rd_ptr];
  wire [2:0]  in_flags = {push_brk, push_fe, push_pe};
  wire [7:0]  in_data  = push_brk ? 8'h00 : push_data;
  wire        inc      = push_ok & (|in_flags);
  wire        dec      = pop_ok & (|head[10:8]);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {in_flags, in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
      ovr_q   <= 1'b0;
      last_q  <= 8'h00;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        last_q <= head[7:0];
      end
      count   <= count + CW'(push_ok) - CW'(pop_ok);
      err_cnt <= err_cnt + CW'(inc) - CW'(dec);
      if (ovf)         ovr_q <= 1'b1;
      else if (rd_lsr) ovr_q <= 1'b0;
    end
  end

  wire tx_empty = (tx_level == '0);

  assign rhr_data = empty ? last_q : head[7:0];
  assign lsr = {(err_cnt != '0),
                tx_empty & ~tx_shift_busy,
                tx_empty,
                empty ? 3'b000 : head[10:8],
                ovr_q,
                ~empty};
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DEPTH = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     push,
  input logic                     rd_rhr,
  input logic                     rd_lsr,
  input logic [7:0]               lsr,
  input logic [7:0]               rhr_data,
  input logic [$clog2(DEPTH):0]   count,
  input logic [$clog2(DEPTH):0]   err_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_head_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !lsr[0] |-> lsr[4:2] == 3'b000);

  p_summary_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    lsr[7] |-> (lsr[0] && err_cnt <= count));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_rhr && count == '0 && !push) |=> ($stable(rhr_data) && count == '0));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (push && count == CW'(DEPTH) && !rd_rhr) |=> (count == CW'(DEPTH) && lsr[1]));

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr && !(push && count == CW'(DEPTH) && !rd_rhr)) |=> !lsr[1]);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push(push), .rd_rhr(rd_rhr), .rd_lsr(rd_lsr),
  .lsr(lsr), .rhr_data(rhr_data), .count(count), .err_cnt(err_cnt)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  localparam int DEPTH = 8;
  localparam int TXW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 0, push_brk = 0, push_fe = 0, push_pe = 0, rd_rhr = 0, rd_lsr = 0;
  logic [7:0] push_data = 0;
  logic [TXW-1:0] tx_level = 0;
  logic tx_shift_busy = 0;
  logic [7:0] rhr_data, lsr;

  uart_rx_status #(.DEPTH(DEPTH), .TXW(TXW)) dut (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .push_brk(push_brk), .push_fe(push_fe), .push_pe(push_pe),
    .rd_rhr(rd_rhr), .rd_lsr(rd_lsr), .tx_level(tx_level),
    .tx_shift_busy(tx_shift_busy), .rhr_data(rhr_data), .lsr(lsr));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [10:0] q[$];
  logic [7:0]  last_m = 0;
  logic        ovr_m = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    logic [7:0] e_rhr;
    logic [2:0] e_head;
    bit e_err;
    e_err = 0;
    foreach (q[i]) if (|q[i][10:8]) e_err = 1;
    e_rhr  = (q.size() != 0) ? q[0][7:0] : last_m;
    e_head = (q.size() != 0) ? q[0][10:8] : 3'b000;
    chk(rhr_data == e_rhr, (q.size() != 0) ? "R1 rhr" : "R5 rhr", rhr_data, e_rhr);
    chk(lsr[0] == (q.size() != 0), "R1 bit0", lsr[0], q.size() != 0);
    chk(lsr[4:2] == e_head, "R2 head flags", lsr[4:2], e_head);
    chk(lsr[7] == e_err, "R4 bit7", lsr[7], e_err);
    chk(lsr[1] == ovr_m, "R6/R7 overrun", lsr[1], ovr_m);
    chk(lsr[5] == (tx_level == 0), "R8 bit5", lsr[5], tx_level == 0);
    chk(lsr[6] == (tx_level == 0 && !tx_shift_busy), "R8 bit6", lsr[6],
        tx_level == 0 && !tx_shift_busy);
  endtask

  task automatic model_update();
    bit pop_ok, push_ok, full;
    if (rst) begin
      q.delete(); ovr_m = 0; last_m = 0;
    end else begin
      full    = (q.size() == DEPTH);
      pop_ok  = rd_rhr && q.size() != 0;
      push_ok = push && (!full || pop_ok);
      if (pop_ok) begin last_m = q[0][7:0]; void'(q.pop_front()); end
      if (push_ok) q.push_back({push_brk, push_fe, push_pe, push_brk ? 8'h00 : push_data});
      if (push && !push_ok) ovr_m = 1;
      else if (rd_lsr) ovr_m = 0;
    end
  endtask

  task automatic step(input bit r, input bit p, input logic [7:0] d, input bit b,
                      input bit f, input bit pa, input bit rr, input bit rl,
                      input logic [TXW-1:0] tl, input bit tb);
    rst = r; push = p; push_data = d; push_brk = b; push_fe = f; push_pe = pa;
    rd_rhr = rr; rd_lsr = rl; tx_level = tl; tx_shift_busy = tb;
    @(posedge clk);
    model_update();
    cycles++;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "R1 watchdog", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9: reset wins over a push and a read
    step(1, 1, 8'h33, 0, 1, 0, 1, 1, 0, 0);
    chk(lsr == 8'h60, "R9 status after reset", lsr, 8'h60);
    chk(rhr_data == 8'h00, "R9 rhr after reset", rhr_data, 0);
    // R5: read when empty
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R2: head flags belong to oldest entry
    step(0, 1, 8'h11, 0, 0, 0, 0, 0, 3, 0);
    step(0, 1, 8'h22, 0, 1, 1, 0, 0, 3, 1);
    chk(lsr[4:2] == 3'b000, "R2 older clean head", lsr[4:2], 0);
    chk(lsr[7] == 1'b1, "R4 errored entry queued", lsr[7], 1);
    // R3: break stores zero
    step(0, 1, 8'hA5, 1, 0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk(lsr[4:2] == 3'b100, "R3 break head flags", lsr[4:2], 3'b100);
    chk(rhr_data == 8'h00, "R3 break byte", rhr_data, 0);
    // R4: pop last errored while pushing clean
    step(0, 1, 8'h44, 0, 0, 0, 1, 0, 0, 0);
    chk(lsr[7] == 1'b0, "R4 cleared after last errored pop", lsr[7], 0);
    // R6: fill and overflow
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 8'(i + 8'h50), 0, 0, i[0], 0, 0, 1, 0);
    chk(lsr[1] == 1'b1, "R6 overrun set", lsr[1], 1);
    chk(rhr_data == 8'h44, "R6 contents intact", rhr_data, 8'h44);
    step(0, 1, 8'h77, 0, 0, 0, 1, 0, 1, 0);
    // R7: status read clears overrun
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk(lsr[1] == 1'b0, "R7 overrun cleared", lsr[1], 0);
    step(0, 1, 8'h78, 0, 0, 0, 0, 1, 1, 0);
    chk(lsr[1] == 1'b1, "R7 new overrun wins over clear", lsr[1], 1);
    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int pp = (ph % 2 == 0) ? 75 : 30;
      for (int c = 0; c < 100; c++) begin
        int er = $urandom_range(99);
        step(($urandom_range(499) == 0),
             ($urandom_range(99) < pp), 8'($urandom),
             er < 8, (er >= 8 && er < 16), (er >= 12 && er < 22),
             ($urandom_range(99) < 100 - pp), ($urandom_range(99) < 20),
             TXW'($urandom_range(3) == 0 ? 0 : $urandom_range(15)),
             $urandom_range(1) == 1);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule